// File: doc/BRIEF.md
# Serial Angle Readout Port

This block is a read-only three-wire serial port that lets a host fetch an absolute angle word. The angle arrives as a parallel unsigned value that keeps changing; one full revolution spans 2^ANGLE_W codes (4096 for the default 12-bit word). The host pulls the active-low select line, and the block then freezes the angle of that moment into a shift register and begins driving the shared data line. Each falling edge of the host clock moves the word out by one bit, most significant bit first.

Both the select line and the host clock are brought into the fast system clock domain through synchroniser chains and handled by edge detection, so no flop is clocked by the host clock. The data line is presented as a value plus an output-enable pair, so a pad or a bus model outside the block can build the high-impedance driver. A host that samples on the falling edge sees one void leading bit. A host that samples on the rising edge gets the MSB first. Extra clocks return zeros, and the host may stop after any number of bits by releasing select.

Top module: `angle_serial_port`

## Requirements
- R1: While the synchronised select is high, data_oe is 0 and data_out is 0. Both hold this state no later than 3 system clocks after cs_n rises and stay there while cs_n stays high.
- R2: A falling cs_n produces a one-cycle pulse on snap_strobe 3 system clocks later. The same clock edge captures the angle input and sets data_oe to 1.
- R3: After the snapshot, data_out is 0 (the void bit) until the first sclk falling edge. The k-th sclk falling edge (k = 1..ANGLE_W) presents bit ANGLE_W-k of the captured angle within 3 system clocks, so the MSB comes first and the LSB comes last.
- R4: After the snapshot, changes on the angle input do not alter the bits shifted out in that transfer.
- R5: Every sclk falling edge beyond the ANGLE_W-th, with select still low, leaves data_out at 0.
- R6: Raising cs_n after any number of bits (none included) ends the transfer. data_oe returns to 0 within 3 system clocks.
- R7: Each new select assertion takes a fresh snapshot and starts again from the void bit followed by the MSB, whatever happened in the previous transfer.
- R8: sclk rising edges never change data_out. sclk edges while select is high neither shift nor alter the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| angle | input | ANGLE_W | Live unsigned angle, full turn = 2^ANGLE_W codes |
| data_out | output | 1 | Serial data value, 0 when not driven |
| data_oe | output | 1 | Output enable for the serial data driver |
| snap_strobe | output | 1 | One-cycle pulse when the angle is captured |

## Verification
On every cycle the assertions check these relations: the enable opens only together with a snapshot, the first bit is void, data holds between host falling edges, zeros follow once the counted bits are used up, and no snapshot fires while a transfer is open. Only the bench's scenarios can show that the bits carry the captured angle in MSB-first order. The same applies to the effect of a late angle change, to early release at every bit count, and to the fact that clocks while deselected leave the next read untouched.

// File: rtl/angle_serial_port.sv
module angle_serial_port #(
  parameter int ANGLE_W     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic [ANGLE_W-1:0] angle,
  output logic               data_out,
  output logic               data_oe,
  output logic               snap_strobe
);
  localparam int CNT_W   = $clog2(ANGLE_W + 2);
  localparam int LAST_CT = ANGLE_W + 1;

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync;
  logic                   cs_d, sck_d;
  logic                   cs_s, sck_s, cs_fall, sck_fall, shift_en;
  logic [ANGLE_W:0]       shreg;
  logic [CNT_W-1:0]       cnt;
  logic                   oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync  <= '1;
      sck_sync <= '1;
      cs_d     <= 1'b1;
      sck_d    <= 1'b1;
    end else begin
      cs_sync  <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], sclk};
      cs_d     <= cs_s;
      sck_d    <= sck_s;
    end
  end

  assign cs_s     = cs_sync[SYNC_STAGES-1];
  assign sck_s    = sck_sync[SYNC_STAGES-1];
  assign cs_fall  = cs_d & ~cs_s;
  assign sck_fall = sck_d & ~sck_s;
  assign shift_en = ~cs_s & oe_q & sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg       <= '0;
      oe_q        <= 1'b0;
      snap_strobe <= 1'b0;
    end else begin
      oe_q        <= ~cs_s;
      snap_strobe <= cs_fall;
      if (cs_fall)
        shreg <= {1'b0, angle};
      else if (shift_en)
        shreg <= {shreg[ANGLE_W-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (cs_fall)
      cnt <= '0;
    else if (shift_en && cnt != CNT_W'(LAST_CT))
      cnt <= cnt + 1'b1;
  end

  assign data_oe  = oe_q;
  assign data_out = oe_q & shreg[ANGLE_W];

  p_open_with_snap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> snap_strobe);

  p_void_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snap_strobe |-> (data_oe && !data_out));

  p_hold_between_falls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe) && !$past(sck_fall)) |-> $stable(data_out));

  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && cnt == CNT_W'(LAST_CT)) |-> !data_out);

  p_no_snap_while_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_strobe |-> !$past(data_oe));

  p_hiz_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> !data_out);
endmodule

// File: tb/angle_serial_port_bench.sv
module angle_serial_port_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b1;
  logic [W-1:0] angle = '0;
  logic         data_out, data_oe, snap_strobe;

  int total = 0;
  int bad = 0;
  int snaps = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  angle_serial_port #(.ANGLE_W(W)) u_angle_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .angle(angle),
    .data_out(data_out), .data_oe(data_oe), .snap_strobe(snap_strobe));

  always @(negedge clk) if (snap_strobe) snaps++;

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic read(input logic [W-1:0] a, input int nfalls, input bit late_change);
    int s0;
    s0 = snaps;
    angle = a;
    cs_n  = 1'b0;
    wait_n(5);
    chk("R2 snap", snaps - s0, 1);
    chk("R2 oe", int'(data_oe), 1);
    chk("R3 void bit", int'(data_out), 0);
    if (late_change) angle = ~a;
    for (int k = 1; k <= nfalls; k++) begin
      logic prev;
      prev = data_out;
      sclk = 1'b1;
      wait_n(8);
      chk("R8 rise holds", int'(data_out), int'(prev));
      sclk = 1'b0;
      wait_n(8);
      if (k <= W)
        chk(late_change ? "R4 frozen bit" : "R3 bit", int'(data_out), int'(a[W-k]));
      else
        chk("R5 zero fill", int'(data_out), 0);
    end
    sclk  = 1'b1;
    wait_n(4);
    cs_n  = 1'b1;
    wait_n(5);
    chk("R6 release oe", int'(data_oe), 0);
    chk("R1 data quiet", int'(data_out), 0);
    chk("R2 single snap", snaps - s0, 1);
  endtask

  initial begin
    wait_n(3);
    chk("R1 reset oe", int'(data_oe), 0);
    chk("R1 reset data", int'(data_out), 0);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1 idle oe", int'(data_oe), 0);
    read(12'hFFF, W, 1'b0);
    read(12'h000, W, 1'b0);
    read(12'h800, W, 1'b1);
    read(12'h555, W + 4, 1'b0);
    read(12'hAAA, W + 2, 1'b1);
    for (int n = 0; n < W; n++) read(12'hB6D, n, 1'b0);
    read(12'h001, W, 1'b0);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; wait_n(8);
      chk("R1 deselected oe", int'(data_oe), 0);
      sclk = 1'b1; wait_n(8);
    end
    read(12'hC3A, W, 1'b0);
    for (int v = 0; v < 4096; v += 67) read(v[W-1:0], W + 1, v[0]);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule